// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the front end that takes a small 16-bit processor into an interrupt handler. At each instruction boundary it looks at four kinds of request: an internal exception or software interrupt, which carries its own 8-bit type; a non-maskable line; a maskable line; and the single-step trap. It picks one of them in a fixed order and acknowledges it. It then runs the entry sequence on a word-wide memory port. The sequence saves the flag word, the code segment and the instruction pointer on the stack, and it reads the handler address from the vector table, which starts at address zero.

When the sequence completes, the block presents the new code segment, instruction pointer, stack pointer and flag word for one cycle. The surrounding core loads these values. Every memory access waits for the memory's ready signal. A rising edge on the non-maskable line is held pending, so a short pulse that arrives during a busy sequence is not lost.

Top module: `irq_entry_seq`

## Requirements
- R1: Requests are accepted only while idle, in a cycle where `insn_done` is 1. The priority is exception/software (ack_src 0) over non-maskable (ack_src 1) over maskable (ack_src 2) over single-step (ack_src 3). `ack` is high for one cycle, the cycle after acceptance.
- R2: The maskable request is taken only when flag bit 9 (interrupt enable) of `flags_in` is 1. The non-maskable request is taken whatever the value of that bit.
- R3: A rising edge on `nmi_in` is latched until a non-maskable entry is accepted. An edge that arrives during a busy sequence is served at a later boundary.
- R4: The type number depends on the source. An exception uses `exc_type` and the non-maskable request uses type 2. Single-step uses type 1 and is requested when flag bit 8 is 1. A maskable entry uses `intr_vec` as sampled in the cycle in which `ack` is high.
- R5: The entry writes three words, with `mem_we` at 1, in this order: the flag word to SP-2, then CS to SP-4, then IP to SP-6. Here SP is the value of `sp_in` at acceptance.
- R6: After the writes, the block reads the word at byte address type*4, which becomes the new IP. It then reads the word at type*4+2, which becomes the new CS.
- R7: Each access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ready` is 1.
- R8: After the last read, `done` is high for one cycle. In that cycle `new_ip` and `new_cs` hold the values read, `new_sp` is SP-6, and `flags_out` is the saved flag word with bits 9 and 8 cleared.
- R9: While a sequence is in progress, `insn_done` and the request inputs have no effect on it. At most one of `ack`, `mem_req` and `done` is high in any cycle.
- R10: Under reset, `ack`, `mem_req`, `mem_we` and `done` are 0, and no non-maskable edge is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Instruction boundary strobe |
| exc_req | input | 1 | Exception or software interrupt request |
| exc_type | input | 8 | Type number of the exception request |
| nmi_in | input | 1 | Non-maskable request, edge sensitive |
| intr_req | input | 1 | Maskable request, level |
| intr_vec | input | 8 | Type supplied for a maskable request |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Return instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| mem_ready | input | 1 | Memory access completes this cycle |
| mem_rdata | input | 16 | Memory read data |
| ack | output | 1 | Entry acknowledged |
| ack_src | output | 2 | Source of the acknowledged entry |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| done | output | 1 | Entry complete, new state valid |
| new_cs | output | 16 | Handler code segment |
| new_ip | output | 16 | Handler instruction pointer |
| new_sp | output | 16 | Stack pointer after the pushes |
| flags_out | output | 16 | Flag word with enable and trap cleared |

## Verification
The assertions assume that memory answers every request eventually. They also assume that the core keeps `flags_in`, `cs_in`, `ip_in` and `sp_in` meaningful only at a boundary, and that `exc_req` is held until it is acknowledged. The stimulus keeps to these rules: it drops an exception request only after the acknowledge, and it drives `mem_ready` from a shift register that never stays at 0 for long. Within those rules, the stimulus holds the boundary strobe high through whole sequences and pulses the non-maskable line mid-sequence. It also switches the maskable vector during the acknowledge cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SRC_EXC  = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_INTR = 2'd2,
    SRC_STEP = 2'd3
  } irq_src_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ACK   = 3'd1,
    ST_PUSH  = 3'd2,
    ST_FETCH = 3'd3,
    ST_DONE  = 3'd4
  } seq_st_e;

  localparam int PUSH_WORDS = 3;
  localparam int VEC_WORDS  = 2;

endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic take,
  output logic pend
);

  logic prev_q, pend_q, pend_d, edge_seen;

  assign edge_seen = nmi_in & ~prev_q;

  // a fresh edge wins over the clear of an older one
  always_comb begin
    pend_d = pend_q;
    if (take)      pend_d = 1'b0;
    if (edge_seen) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_in;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int TW        = 8,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1
) (
  input  logic          exc_req,
  input  logic [TW-1:0] exc_type,
  input  logic          nmi_pend,
  input  logic          intr_req,
  input  logic [DW-1:0] flags,
  output logic          any,
  output irq_src_e      src,
  output logic [TW-1:0] type_num
);

  logic intr_ok, step_ok;

  assign intr_ok = intr_req & flags[IF_BIT];
  assign step_ok = flags[TF_BIT];

  always_comb begin
    any      = 1'b1;
    src      = SRC_EXC;
    type_num = '0;
    if (exc_req) begin
      type_num = exc_type;
    end else if (nmi_pend) begin
      src      = SRC_NMI;
      type_num = TW'(NMI_TYPE);
    end else if (intr_ok) begin
      src      = SRC_INTR;
    end else if (step_ok) begin
      src      = SRC_STEP;
      type_num = TW'(STEP_TYPE);
    end else begin
      any      = 1'b0;
    end
  end

endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
  import irq_pkg::*;
#(
  parameter int DW     = 16,
  parameter int TW     = 8,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          req_any,
  input  irq_src_e      req_src,
  input  logic [TW-1:0] req_type,
  input  logic [TW-1:0] vec_in,
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] ip_in,
  input  logic [DW-1:0] sp_in,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          accept,
  output logic          ack,
  output irq_src_e      ack_src,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic [DW-1:0] new_cs,
  output logic [DW-1:0] new_ip,
  output logic [DW-1:0] new_sp,
  output logic [DW-1:0] flags_out
);

  localparam int IDXW = 2;
  localparam logic [IDXW-1:0] PUSH_LAST = IDXW'(PUSH_WORDS - 1);
  localparam logic [IDXW-1:0] VEC_LAST  = IDXW'(VEC_WORDS - 1);
  localparam logic [DW-1:0]   WORD_B    = DW'(2);
  localparam logic [DW-1:0]   CLR_MASK  = ~((DW'(1) << IF_BIT) | (DW'(1) << TF_BIT));

  seq_st_e         st_q, st_d;
  logic [IDXW-1:0] idx_q, idx_d;
  irq_src_e        src_q, src_d;
  logic [TW-1:0]   type_q, type_d;
  logic [DW-1:0]   flags_q, cs_q, ip_q;
  logic [DW-1:0]   sp_q, sp_d;
  logic [DW-1:0]   ipn_q, csn_q;
  logic            cap_en, sp_en, ipn_en, csn_en;
  logic [DW-1:0]   vec_addr;

  assign accept = (st_q == ST_IDLE) & boundary & req_any;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    src_d  = src_q;
    type_d = type_q;
    sp_d   = sp_q;
    cap_en = 1'b0;
    sp_en  = 1'b0;
    ipn_en = 1'b0;
    csn_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_ACK;
          src_d  = req_src;
          type_d = req_type;
          sp_d   = sp_in;
          sp_en  = 1'b1;
          cap_en = 1'b1;
        end
      end
      ST_ACK: begin
        if (src_q == SRC_INTR) type_d = vec_in;
        st_d  = ST_PUSH;
        idx_d = '0;
      end
      ST_PUSH: begin
        if (mem_ready) begin
          sp_d  = sp_q - WORD_B;
          sp_en = 1'b1;
          if (idx_q == PUSH_LAST) begin
            st_d  = ST_FETCH;
            idx_d = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_FETCH: begin
        if (mem_ready) begin
          if (idx_q == '0) ipn_en = 1'b1;
          else             csn_en = 1'b1;
          if (idx_q == VEC_LAST) st_d = ST_DONE;
          else                   idx_d = idx_q + 1'b1;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      src_q   <= SRC_EXC;
      type_q  <= '0;
      flags_q <= '0;
      cs_q    <= '0;
      ip_q    <= '0;
      sp_q    <= '0;
      ipn_q   <= '0;
      csn_q   <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      src_q  <= src_d;
      type_q <= type_d;
      if (cap_en) begin
        flags_q <= flags_in;
        cs_q    <= cs_in;
        ip_q    <= ip_in;
      end
      if (sp_en)  sp_q  <= sp_d;
      if (ipn_en) ipn_q <= mem_rdata;
      if (csn_en) csn_q <= mem_rdata;
    end
  end

  assign vec_addr = DW'({type_q, 2'b00}) + DW'({idx_q, 1'b0});

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (st_q == ST_PUSH) begin
      mem_req  = 1'b1;
      mem_we   = 1'b1;
      mem_addr = sp_q - WORD_B;
      case (idx_q)
        2'd0:    mem_wdata = flags_q;
        2'd1:    mem_wdata = cs_q;
        default: mem_wdata = ip_q;
      endcase
    end else if (st_q == ST_FETCH) begin
      mem_req  = 1'b1;
      mem_addr = vec_addr;
    end
  end

  assign ack       = (st_q == ST_ACK);
  assign ack_src   = src_q;
  assign done      = (st_q == ST_DONE);
  assign new_cs    = csn_q;
  assign new_ip    = ipn_q;
  assign new_sp    = sp_q;
  assign flags_out = flags_q & CLR_MASK;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_pkg::*;
#(
  parameter int DW        = 16,
  parameter int TW        = 8,
  parameter int IF_BIT    = 9,
  parameter int TF_BIT    = 8,
  parameter int NMI_TYPE  = 2,
  parameter int STEP_TYPE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          exc_req,
  input  logic [TW-1:0] exc_type,
  input  logic          nmi_in,
  input  logic          intr_req,
  input  logic [TW-1:0] intr_vec,
  input  logic [DW-1:0] flags_in,
  input  logic [DW-1:0] cs_in,
  input  logic [DW-1:0] ip_in,
  input  logic [DW-1:0] sp_in,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          ack,
  output logic [1:0]    ack_src,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          done,
  output logic [DW-1:0] new_cs,
  output logic [DW-1:0] new_ip,
  output logic [DW-1:0] new_sp,
  output logic [DW-1:0] flags_out
);

  logic          nmi_pend, req_any, accept, nmi_take;
  irq_src_e      req_src, src_out;
  logic [TW-1:0] req_type;

  assign nmi_take = accept & (req_src == SRC_NMI);

  irq_nmi_latch u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_in (nmi_in),
    .take   (nmi_take),
    .pend   (nmi_pend)
  );

  irq_arbiter #(
    .DW(DW), .TW(TW), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT),
    .NMI_TYPE(NMI_TYPE), .STEP_TYPE(STEP_TYPE)
  ) u_arb (
    .exc_req  (exc_req),
    .exc_type (exc_type),
    .nmi_pend (nmi_pend),
    .intr_req (intr_req),
    .flags    (flags_in),
    .any      (req_any),
    .src      (req_src),
    .type_num (req_type)
  );

  irq_entry_fsm #(
    .DW(DW), .TW(TW), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .boundary  (insn_done),
    .req_any   (req_any),
    .req_src   (req_src),
    .req_type  (req_type),
    .vec_in    (intr_vec),
    .flags_in  (flags_in),
    .cs_in     (cs_in),
    .ip_in     (ip_in),
    .sp_in     (sp_in),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .accept    (accept),
    .ack       (ack),
    .ack_src   (src_out),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .done      (done),
    .new_cs    (new_cs),
    .new_ip    (new_ip),
    .new_sp    (new_sp),
    .flags_out (flags_out)
  );

  assign ack_src = src_out;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int DW     = 16,
  parameter int TW     = 8,
  parameter int IF_BIT = 9,
  parameter int TF_BIT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_done,
  input logic [DW-1:0] flags_in,
  input logic          mem_ready,
  input logic          ack,
  input logic [1:0]    ack_src,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          done,
  input logic [DW-1:0] flags_out
);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  assert_ack_at_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(insn_done));

  assert_mask_honoured_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_src == 2'd2 |-> $past(flags_in[IF_BIT]));

  assert_step_needs_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack && ack_src == 2'd3 |-> $past(flags_in[TF_BIT]));

  assert_push_follows_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> mem_req && mem_we);

  assert_vector_in_table_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> !mem_addr[0] && ((mem_addr >> (TW + 2)) == '0));

  assert_flags_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !flags_out[IF_BIT] && !flags_out[TF_BIT]);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack, mem_req, done}));

endmodule

bind irq_entry_seq irq_entry_chk #(
  .DW(DW), .TW(TW), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)
) u_chk (.*);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [15:0] data;
  } acc_t;

  logic        clk = 1'b0;
  logic        rst_n, insn_done, exc_req, nmi_in, intr_req, mem_ready;
  logic [7:0]  exc_type, intr_vec;
  logic [15:0] flags_in, cs_in, ip_in, sp_in, mem_rdata;
  logic        ack, mem_req, mem_we, done;
  logic [1:0]  ack_src;
  logic [15:0] mem_addr, mem_wdata, new_cs, new_ip, new_sp, flags_out;

  int errs = 0;
  int checks = 0;
  bit slow = 0;
  logic [7:0] lfsr = 8'h5b;
  string scen = "reset";

  always #5 clk = ~clk;

  irq_entry_seq uut (.*);

  function automatic logic [15:0] memf(logic [15:0] a);
    return (a ^ 16'h5a5a) + {a[7:0], a[15:8]};
  endfunction

  assign mem_rdata = (mem_req && !mem_we) ? memf(mem_addr) : 16'h0000;

  // behavioural reference
  int          m_ph;
  bit          m_nprev, m_npend;
  int          m_src, m_nreads;
  logic [7:0]  m_type;
  logic [15:0] m_flags, m_sp, m_ip, m_cs;
  acc_t        q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_nprev = 0; m_npend = 0; q.delete();
    end else begin
      bit edge_now;
      edge_now = nmi_in && !m_nprev;
      m_nprev = nmi_in;
      case (m_ph)
        0: if (insn_done) begin
          m_src = -1;
          if (exc_req) begin m_src = 0; m_type = exc_type; end
          else if (m_npend) begin m_src = 1; m_type = 8'd2; m_npend = 0; end
          else if (intr_req && flags_in[9]) m_src = 2;
          else if (flags_in[8]) begin m_src = 3; m_type = 8'd1; end
          if (m_src >= 0) begin
            m_ph = 1; m_flags = flags_in; m_sp = sp_in;
            q.push_back({1'b1, sp_in - 16'd2, flags_in});
            q.push_back({1'b1, sp_in - 16'd4, cs_in});
            q.push_back({1'b1, sp_in - 16'd6, ip_in});
          end
        end
        1: begin
          if (m_src == 2) m_type = intr_vec;
          q.push_back({1'b0, {6'd0, m_type, 2'b00}, 16'h0});
          q.push_back({1'b0, {6'd0, m_type, 2'b10}, 16'h0});
          m_nreads = 0; m_ph = 2;
        end
        2: if (mem_ready) begin
          acc_t a;
          a = q.pop_front();
          if (!a.we) begin
            if (m_nreads == 0) m_ip = memf(a.addr); else m_cs = memf(a.addr);
            m_nreads++;
          end
          if (q.size() == 0) m_ph = 3;
        end
        default: m_ph = 0;
      endcase
      if (edge_now) m_npend = 1;
    end
  end

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s (%s) got=%h exp=%h t=%0t", req, scen, got, exp, $time);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R1 ack", {15'd0, ack}, {15'd0, m_ph == 1});
      if (m_ph == 1) check("R1 ack_src", {14'd0, ack_src}, 16'(m_src));
      check("R7 mem_req", {15'd0, mem_req}, {15'd0, m_ph == 2});
      if (m_ph == 2 && q.size() > 0) begin
        check("R7 mem_we", {15'd0, mem_we}, {15'd0, q[0].we});
        if (q[0].we) begin
          check("R5 push addr", mem_addr, q[0].addr);
          check("R5 push data", mem_wdata, q[0].data);
        end else begin
          check("R6 vector addr", mem_addr, q[0].addr);
        end
      end
      check("R8 done", {15'd0, done}, {15'd0, m_ph == 3});
      if (m_ph == 3) begin
        check("R8 new_ip", new_ip, m_ip);
        check("R8 new_cs", new_cs, m_cs);
        check("R8 new_sp", new_sp, m_sp - 16'd6);
        check("R8 flags_out", flags_out, m_flags & 16'hfcff);
      end
    end
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    mem_ready <= slow ? (lfsr[0] & lfsr[2]) | lfsr[6] : 1'b1;
  end

  task automatic boundary();
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) insn_done = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_ph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic nmi_pulse();
    @(negedge clk) nmi_in = 1'b1;
    @(negedge clk) nmi_in = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int acks;
    rst_n = 0; insn_done = 0; exc_req = 0; nmi_in = 0; intr_req = 0;
    exc_type = 0; intr_vec = 8'h40; flags_in = 0; cs_in = 16'h1234;
    ip_in = 16'h5678; sp_in = 16'h0100; mem_ready = 1;
    repeat (3) @(negedge clk);
    // R10: outputs quiet under reset
    check("R10 ack", {15'd0, ack}, 16'h0);
    check("R10 mem_req", {15'd0, mem_req}, 16'h0);
    check("R10 mem_we", {15'd0, mem_we}, 16'h0);
    check("R10 done", {15'd0, done}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    // R10: no stale NMI after reset, boundary with nothing pending
    scen = "R10 idle boundary";
    boundary(); repeat (3) @(negedge clk);

    // R5 R6 R8: exception entry, fast memory
    scen = "R5 exception";
    flags_in = 16'h03c5; exc_type = 8'h21; exc_req = 1;
    boundary(); exc_req = 0; wait_idle();

    // R1: all four pending, served one per boundary in priority order
    scen = "R1 priority";
    flags_in = 16'h0300; exc_type = 8'h00; exc_req = 1; intr_req = 1;
    nmi_pulse();
    boundary(); exc_req = 0; wait_idle();
    boundary(); wait_idle();
    boundary(); wait_idle();
    intr_req = 0;
    boundary(); wait_idle();

    // R2: maskable blocked with enable clear, NMI still taken
    scen = "R2 masked";
    flags_in = 16'h0000; intr_req = 1; acks = 0;
    boundary();
    repeat (4) begin @(negedge clk); if (ack) acks++; end
    check("R2 no ack when masked", 16'(acks), 16'h0);
    nmi_pulse(); boundary(); wait_idle();
    intr_req = 0;

    // R3 R7 R9: slow memory, boundary strobe held, NMI pulse mid-sequence
    scen = "R3 nmi during busy";
    slow = 1; flags_in = 16'h0001; sp_in = 16'h8000; exc_type = 8'h03; exc_req = 1;
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) exc_req = 0;
    repeat (3) @(negedge clk);
    nmi_pulse();
    wait_idle();
    wait_idle();
    insn_done = 0;
    repeat (3) @(negedge clk);
    slow = 0;

    // R4: single-step type, and maskable vector taken in the ack cycle
    scen = "R4 step";
    flags_in = 16'h0100; boundary(); wait_idle();
    scen = "R4 vector sampled at ack";
    flags_in = 16'h0200; intr_req = 1; intr_vec = 8'h77;
    @(negedge clk) insn_done = 1'b1;
    @(negedge clk) begin insn_done = 1'b0; intr_vec = 8'h88; intr_req = 0; end
    check("R4 ack seen", {15'd0, ack}, 16'h1);
    wait_idle();
    intr_vec = 8'hff;

    // R6: top of the vector table
    scen = "R6 type ff";
    flags_in = 16'h0000; exc_type = 8'hff; exc_req = 1; sp_in = 16'h0004;
    boundary(); exc_req = 0; wait_idle();

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule